// File: doc/BRIEF.md
# Byte-Wide Conversion Result Bus Interface

This block sits between a converter core and a processor bus that is eight bits wide. The core delivers a 15-bit magnitude, a sign flag, an overrange flag and a one-cycle pulse that marks the result as valid. The block keeps the latest result and lets the processor read it one byte at a time. It also turns processor writes into a conversion start pulse. All strobes and selects are sampled on the block clock. The block has no three-state cell of its own: it produces the byte to put on the bus together with an enable for the chip-level driver.

Access is only possible when the active-high select is high and the active-low enable is low. In demand mode, select inputs choose which byte is read. One input picks the low or the high byte of the 16-bit word, which is `{sign, magnitude}`. A second input changes the high byte so that it shows the sign and the overrange flag. In stream mode the select inputs are ignored. Each completed read moves an internal byte slot through low byte, high byte and status byte, then back to the low byte, so software reads three bytes in a row with no address changes. A result that arrives while a read is under way waits until the read ends, so the bytes of one sequence always belong to the same result.

Top module: `adc_byte_bus`

## Requirements
- R1: The block counts as selected only when `chip_sel` is 1 and `chip_en_n` is 0 in the same cycle. When it is not selected, `bus_drive` stays 0, no start pulse is produced and the byte slot does not move.
- R2: `bus_drive` is 1 exactly when the block is selected and `rd_n` is 0. While `bus_drive` is 0, `bus_data` is 8'h00.
- R3: In demand mode (`stream_mode`=0), `wr_n` going low while the block is selected produces a single one-cycle pulse on `conv_go` in the next cycle, however long `wr_n` stays low. Stream mode never produces the pulse.
- R4: In demand mode with `flag_sel`=0, `byte_hi`=0 drives magnitude bits 7..0 and `byte_hi`=1 drives `{sign, magnitude bits 14..8}`.
- R5: In demand mode with `byte_hi`=1 and `flag_sel`=1, bit 7 carries the sign, bit 6 carries the overrange flag and bits 5..0 carry magnitude bits 13..8. `flag_sel` has no effect when `byte_hi`=0.
- R6: In stream mode, the end of each selected read (`rd_n` rising, or the select dropping while `rd_n` is low) moves the slot from low to high, from high to status, and from status back to low. `byte_hi` and `flag_sel` are ignored.
- R7: The status byte in stream mode is `{sign, overrange, 6'b000000}`.
- R8: A `core_done` pulse with no read in progress stores the new result at that clock edge and puts the slot back on the low byte.
- R9: A `core_done` pulse that arrives during a selected read leaves the visible result unchanged until the read ends. It is then stored, the slot goes back to the low byte, and a later pulse during the same read replaces the waiting result.
- R10: Synchronous reset clears the stored result to zero, sets the slot to the low byte and clears `conv_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_sel | input | 1 | Select, active high |
| chip_en_n | input | 1 | Enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| stream_mode | input | 1 | 1 = stream mode, 0 = demand mode |
| byte_hi | input | 1 | Demand mode: 0 = low byte, 1 = high byte |
| flag_sel | input | 1 | Demand mode: replace the high byte's top bits with sign and overrange |
| core_mag | input | 15 | Result magnitude from the converter core |
| core_neg | input | 1 | Result sign (1 = negative) |
| core_ovr | input | 1 | Overrange flag |
| core_done | input | 1 | One-cycle pulse: result inputs are valid |
| bus_data | output | 8 | Byte for the three-state bus driver |
| bus_drive | output | 1 | Enable for the three-state bus driver |
| conv_go | output | 1 | One-cycle conversion start pulse |

## Verification
The assertions check these rules on every cycle:
- the start pulse is one cycle long and only follows a selected demand-mode write;
- the bus is driven only while the block is selected and is quiet (8'h00) while released;
- the stored result does not change in the cycle after an active read;
- the byte slot never leaves its three legal values, never moves in demand mode, and is on the low byte after every load.

Only the bench's scenarios can show the byte contents. These are the byte order and wrap-around over a stream read sequence, the sign and overrange substitution in demand mode, and the fact that a result held back during a read, including one replaced by a second pulse, is the one seen after release. The bench checks these against its own model on every clock.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    localparam int MAG_W  = 15;
    localparam int BUS_W  = 8;
    localparam int WORD_W = MAG_W + 1;
    localparam int HI_W   = WORD_W - BUS_W;

    typedef struct packed {
        logic             neg;
        logic             ovr;
        logic [MAG_W-1:0] mag;
    } conv_t;

    typedef enum logic [1:0] {
        SLOT_LO = 2'd0,
        SLOT_HI = 2'd1,
        SLOT_ST = 2'd2
    } slot_e;

    function automatic slot_e slot_next(input slot_e s);
        case (s)
            SLOT_LO: slot_next = SLOT_HI;
            SLOT_HI: slot_next = SLOT_ST;
            default: slot_next = SLOT_LO;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input conv_t c);
        word_of = {c.neg, c.mag};
    endfunction

    function automatic logic [BUS_W-1:0] status_of(input conv_t c);
        status_of = {c.neg, c.ovr, {(BUS_W-2){1'b0}}};
    endfunction

    function automatic logic [BUS_W-1:0] flagged_hi(input conv_t c);
        logic [WORD_W-1:0] w;
        w = word_of(c);
        flagged_hi = {c.neg, c.ovr, w[WORD_W-3:BUS_W]};
    endfunction

endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode (
    input  logic clk,
    input  logic rst,
    input  logic chip_sel,
    input  logic chip_en_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic stream_mode,
    output logic rd_act,
    output logic rd_end,
    output logic conv_go
);
    logic sel;
    logic wr_act;
    logic rd_act_q;
    logic wr_act_q;

    assign sel    = chip_sel & ~chip_en_n;
    assign rd_act = sel & ~rd_n;
    assign wr_act = sel & ~wr_n & ~stream_mode;
    assign rd_end = rd_act_q & ~rd_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
            conv_go  <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
            wr_act_q <= wr_act;
            conv_go  <= wr_act & ~wr_act_q;
        end
    end

    p_go_single_r3: assert property (@(posedge clk) disable iff (rst)
        conv_go |=> !conv_go);
    p_go_demand_r3: assert property (@(posedge clk) disable iff (rst)
        conv_go |-> $past(!stream_mode && !wr_n));
    p_go_selected_r1: assert property (@(posedge clk) disable iff (rst)
        conv_go |-> $past(chip_sel && !chip_en_n));

endmodule

// File: rtl/adc_bus_hold.sv
module adc_bus_hold
    import adc_bus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  conv_t core_in,
    input  logic  core_done,
    input  logic  rd_act,
    output conv_t cur,
    output logic  load
);
    conv_t pend;
    logic  pend_v;

    always_comb begin
        load = 1'b0;
        if (core_done)
            load = ~rd_act;
        else if (pend_v)
            load = ~rd_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
        end else if (core_done) begin
            if (rd_act) begin
                pend   <= core_in;
                pend_v <= 1'b1;
            end else begin
                cur    <= core_in;
                pend_v <= 1'b0;
            end
        end else if (pend_v && !rd_act) begin
            cur    <= pend;
            pend_v <= 1'b0;
        end
    end

    p_hold_during_read_r9: assert property (@(posedge clk) disable iff (rst)
        rd_act |=> (cur == $past(cur)));
    p_no_silent_change_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cur == $past(cur)));

endmodule

// File: rtl/adc_bus_slot.sv
module adc_bus_slot
    import adc_bus_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  stream_mode,
    input  logic  rd_end,
    output slot_e slot
);
    always_ff @(posedge clk) begin
        if (rst)
            slot <= SLOT_LO;
        else if (load)
            slot <= SLOT_LO;
        else if (stream_mode && rd_end)
            slot <= slot_next(slot);
    end

    p_slot_legal_r6: assert property (@(posedge clk) disable iff (rst)
        slot != 2'd3);
    p_load_low_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> slot == SLOT_LO);
    p_demand_still_r6: assert property (@(posedge clk) disable iff (rst)
        (!stream_mode && !load) |=> $stable(slot));

endmodule

// File: rtl/adc_bus_mux.sv
module adc_bus_mux
    import adc_bus_pkg::*;
(
    input  conv_t             cur,
    input  slot_e             slot,
    input  logic              stream_mode,
    input  logic              byte_hi,
    input  logic              flag_sel,
    input  logic              rd_act,
    output logic [BUS_W-1:0]  bus_data,
    output logic              bus_drive
);
    logic [WORD_W-1:0] word;
    logic [BUS_W-1:0]  lo_b;
    logic [BUS_W-1:0]  hi_b;
    logic [BUS_W-1:0]  pick;

    assign word = word_of(cur);
    assign lo_b = word[BUS_W-1:0];
    assign hi_b = word[WORD_W-1:BUS_W];

    always_comb begin
        if (stream_mode) begin
            case (slot)
                SLOT_LO: pick = lo_b;
                SLOT_HI: pick = hi_b;
                default: pick = status_of(cur);
            endcase
        end else if (!byte_hi) begin
            pick = lo_b;
        end else if (flag_sel) begin
            pick = flagged_hi(cur);
        end else begin
            pick = hi_b;
        end
    end

    assign bus_drive = rd_act;
    assign bus_data  = rd_act ? pick : '0;

    always_comb begin
        a_quiet_release_r2: assert (bus_drive || bus_data == '0);
    end

endmodule

// File: rtl/adc_byte_bus.sv
module adc_byte_bus
    import adc_bus_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                chip_sel,
    input  logic                chip_en_n,
    input  logic                wr_n,
    input  logic                rd_n,
    input  logic                stream_mode,
    input  logic                byte_hi,
    input  logic                flag_sel,
    input  logic [MAG_W-1:0]    core_mag,
    input  logic                core_neg,
    input  logic                core_ovr,
    input  logic                core_done,
    output logic [BUS_W-1:0]    bus_data,
    output logic                bus_drive,
    output logic                conv_go
);
    logic  rd_act;
    logic  rd_end;
    logic  load;
    conv_t core_in;
    conv_t cur;
    slot_e slot;

    assign core_in = '{neg: core_neg, ovr: core_ovr, mag: core_mag};

    adc_bus_decode u_decode (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .chip_en_n(chip_en_n),
        .rd_n(rd_n), .wr_n(wr_n), .stream_mode(stream_mode),
        .rd_act(rd_act), .rd_end(rd_end), .conv_go(conv_go)
    );

    adc_bus_hold u_hold (
        .clk(clk), .rst(rst), .core_in(core_in), .core_done(core_done),
        .rd_act(rd_act), .cur(cur), .load(load)
    );

    adc_bus_slot u_slot (
        .clk(clk), .rst(rst), .load(load), .stream_mode(stream_mode),
        .rd_end(rd_end), .slot(slot)
    );

    adc_bus_mux u_mux (
        .cur(cur), .slot(slot), .stream_mode(stream_mode), .byte_hi(byte_hi),
        .flag_sel(flag_sel), .rd_act(rd_act), .bus_data(bus_data),
        .bus_drive(bus_drive)
    );

    p_drive_selected_r1: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (chip_sel && !chip_en_n && !rd_n));
    p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
        (chip_sel && !chip_en_n && !rd_n) |-> bus_drive);

endmodule

// File: tb/test_adc_byte_bus.sv
module test_adc_byte_bus;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chip_sel = 1'b0, chip_en_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic        stream_mode = 1'b0, byte_hi = 1'b0, flag_sel = 1'b0;
    logic [14:0] core_mag = '0;
    logic        core_neg = 1'b0, core_ovr = 1'b0, core_done = 1'b0;
    logic [7:0]  bus_data;
    logic        bus_drive, conv_go;

    int total = 0;
    int bad   = 0;
    bit run   = 1'b0;

    always #10 clk = ~clk;

    adc_byte_bus i_adc_byte_bus (
        .clk(clk), .rst(rst), .chip_sel(chip_sel), .chip_en_n(chip_en_n),
        .wr_n(wr_n), .rd_n(rd_n), .stream_mode(stream_mode), .byte_hi(byte_hi),
        .flag_sel(flag_sel), .core_mag(core_mag), .core_neg(core_neg),
        .core_ovr(core_ovr), .core_done(core_done), .bus_data(bus_data),
        .bus_drive(bus_drive), .conv_go(conv_go)
    );

    // behavioural reference model
    int m_mag = 0, m_neg = 0, m_ovr = 0;
    int q_mag[$];
    int q_neg[$];
    int q_ovr[$];
    int m_slot = 0;
    bit m_ra = 0, m_wa = 0, m_go = 0;

    always @(posedge clk) begin
        bit sel, ra, wa, rend, ld;
        if (rst) begin
            m_mag = 0; m_neg = 0; m_ovr = 0; m_slot = 0;
            m_ra = 0; m_wa = 0; m_go = 0;
            q_mag.delete(); q_neg.delete(); q_ovr.delete();
        end else begin
            sel  = chip_sel && !chip_en_n;
            ra   = sel && !rd_n;
            wa   = sel && !wr_n && !stream_mode;
            m_go = wa && !m_wa;
            m_wa = wa;
            rend = m_ra && !ra;
            m_ra = ra;
            ld   = 0;
            if (core_done) begin
                q_mag.delete(); q_neg.delete(); q_ovr.delete();
                if (ra) begin
                    q_mag.push_back(int'(core_mag));
                    q_neg.push_back(int'(core_neg));
                    q_ovr.push_back(int'(core_ovr));
                end else begin
                    m_mag = int'(core_mag); m_neg = int'(core_neg); m_ovr = int'(core_ovr);
                    ld = 1;
                end
            end else if (q_mag.size() > 0 && !ra) begin
                m_mag = q_mag.pop_front(); m_neg = q_neg.pop_front(); m_ovr = q_ovr.pop_front();
                ld = 1;
            end
            if (ld) m_slot = 0;
            else if (stream_mode && rend) m_slot = (m_slot == 2) ? 0 : m_slot + 1;
        end
    end

    function automatic int exp_byte();
        int lo, hi, hf, st;
        lo = m_mag % 256;
        hi = m_neg * 128 + (m_mag / 256) % 128;
        hf = m_neg * 128 + m_ovr * 64 + (m_mag / 256) % 64;
        st = m_neg * 128 + m_ovr * 64;
        if (stream_mode) return (m_slot == 0) ? lo : (m_slot == 1) ? hi : st;
        if (!byte_hi) return lo;
        return flag_sel ? hf : hi;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare every clock, between edges
    always @(negedge clk) begin
        int eo, ed;
        string t;
        #5;
        if (run && !rst) begin
            eo = (chip_sel && !chip_en_n && !rd_n) ? 1 : 0;
            ed = eo ? exp_byte() : 0;
            if (!eo) t = "R2";
            else if (stream_mode) t = (m_slot == 2) ? "R7" : "R6";
            else t = (byte_hi && flag_sel) ? "R5" : "R4";
            chk("R2 drive", int'(bus_drive), eo);
            chk(t, int'(bus_data), ed);
            chk("R3 start", int'(conv_go), int'(m_go));
        end
    end

    task automatic sel_on();
        chip_sel = 1'b1; chip_en_n = 1'b0;
    endtask

    task automatic push(input logic [14:0] m, input logic s, input logic o);
        @(negedge clk);
        core_mag = m; core_neg = s; core_ovr = o; core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic rd_byte(input string tag, input int exp);
        @(negedge clk);
        rd_n = 1'b0;
        #6;
        chk(tag, int'(bus_data), exp);
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic count_go(input string tag, input int exp);
        int n;
        n = 0;
        @(negedge clk);
        wr_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #5;
            n += int'(conv_go);
        end
        wr_n = 1'b1;
        chk(tag, n, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run = 1'b1;
        #6;
        chk("R10 drive", int'(bus_drive), 0);
        chk("R10 start", int'(conv_go), 0);
        sel_on();
        rd_byte("R10 low byte zero", 0);
        byte_hi = 1'b1;
        rd_byte("R10 high byte zero", 0);
        byte_hi = 1'b0;

        // R1: each half of the select alone is not enough
        @(negedge clk);
        chip_sel = 1'b0; rd_n = 1'b0;
        #6 chk("R1 cs low", int'(bus_drive), 0);
        @(negedge clk);
        chip_sel = 1'b1; chip_en_n = 1'b1;
        #6 chk("R1 ce high", int'(bus_drive), 0);
        rd_n = 1'b1;
        count_go("R1 no start deselected", 0);
        sel_on();

        // R4 / R5 demand byte selection
        push(15'h5A3C, 1'b1, 1'b0);
        rd_byte("R4 low", 8'h3C);
        byte_hi = 1'b1;
        rd_byte("R4 high", 8'hDA);
        flag_sel = 1'b1;
        rd_byte("R5 high flagged", 8'h9A);
        byte_hi = 1'b0;
        rd_byte("R5 low ignores flag_sel", 8'h3C);
        flag_sel = 1'b0;

        // R3 start pulse
        count_go("R3 single pulse", 1);
        stream_mode = 1'b1;
        count_go("R3 none in stream mode", 0);

        // R6 / R7 stream order and wrap
        push(15'h1234, 1'b0, 1'b1);
        byte_hi = 1'b1; flag_sel = 1'b1;
        rd_byte("R6 first low", 8'h34);
        byte_hi = 1'b0;
        rd_byte("R6 second high", 8'h12);
        rd_byte("R7 third status", 8'h40);
        rd_byte("R6 wrap to low", 8'h34);

        // R8 new result returns slot to low
        push(15'h0777, 1'b1, 1'b1);
        rd_byte("R8 low after load", 8'h77);

        // R9 hold-off during an active read
        @(negedge clk);
        rd_n = 1'b0;
        #6 chk("R9 before pulses", int'(bus_data), 8'h87);
        push(15'h2222, 1'b0, 1'b0);
        push(15'h3333, 1'b0, 1'b1);
        #6 chk("R9 held during read", int'(bus_data), 8'h87);
        @(negedge clk);
        rd_n = 1'b1;
        rd_byte("R9 latest low", 8'h33);
        rd_byte("R9 latest high", 8'h33);
        rd_byte("R9 latest status", 8'h40);

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            chip_sel    = ($urandom % 8) != 0;
            chip_en_n   = ($urandom % 8) == 0;
            rd_n        = ($urandom % 3) != 0;
            wr_n        = ($urandom % 4) != 0;
            byte_hi     = $urandom % 2;
            flag_sel    = $urandom % 2;
            if ($urandom % 40 == 0) stream_mode = ~stream_mode;
            core_mag    = 15'($urandom);
            core_neg    = $urandom % 2;
            core_ovr    = $urandom % 2;
            core_done   = ($urandom % 6) == 0;
        end
        @(negedge clk);
        core_done = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        repeat (2) @(negedge clk);
        run = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule